// File: doc/BRIEF.md
# Per-Bank Activation Timing Tracker

This block sits beside a synchronous DRAM command scheduler and keeps the timing state of every internal bank. Each clock it sees the command the scheduler presents, the target bank and the auto-precharge/all-banks address bit. From that it tells the scheduler, per bank, whether a row activation, a column access (read or write) or a precharge would be legal in the current cycle. It also reports whether a precharge of all banks is legal.

Each bank has a row-open flag and a set of saturating down-counters. These cover the delay from activation to column access, the minimum time a row stays open, the precharge recovery, the full row cycle, write recovery and a pending self-timed precharge. One counter shared by all banks spaces successive activations. All minimums are parameters in clock cycles.

The legality flags are decoded from registered state only, so the scheduler can use them in the same cycle in which it picks a command. A command that the flags mark illegal is ignored.

Top module: `bank_timing_tracker`

## Requirements
- R1: After reset, and whenever reset is asserted, every bank is idle: row_open=0, access_ok=0, pre_ok=0, act_ok all 1 and pre_all_ok=1.
- R2: An ACTIVE accepted in cycle t opens the addressed bank from cycle t+1, and access_ok for that bank first rises in cycle t+T_RCD.
- R3: pre_ok for a bank stays low until cycle t+T_RAS after its ACTIVE in cycle t, and a PRECHARGE presented while pre_ok is low is ignored.
- R4: A PRECHARGE with cmd_a10=0 in cycle t closes only the addressed bank, and that bank's act_ok returns in cycle t+T_RP, provided the row-cycle time has also passed.
- R5: A PRECHARGE with cmd_a10=1 is legal only while pre_all_ok is high, and then it closes every open bank whatever cmd_bank holds.
- R6: After a WRITE in cycle t, pre_ok for that bank stays low until cycle t+BURST_LEN-1+T_WR.
- R7: A READ with cmd_a10=1 in cycle t makes the bank close by itself at the end of cycle t+BURST_LEN. Until then all of its flags are low. Its act_ok returns T_RP cycles after it closes.
- R8: A WRITE with cmd_a10=1 in cycle t makes the bank close by itself at the end of cycle t+BURST_LEN-1+T_WR (never before T_RAS has passed). Its act_ok returns T_RP cycles after it closes.
- R9: After an ACTIVE in cycle t, act_ok is low for every bank until cycle t+T_RRD.
- R10: A bank activated in cycle t cannot be activated again before cycle t+T_RC, even when its precharge recovery has ended earlier.
- R11: A command whose legality flag is low leaves all state unchanged. This includes a READ or WRITE to an idle bank and an ACTIVE inside the spacing window.
- R12: cmd_code encodes 0 = NOP, 1 = ACTIVE, 2 = READ, 3 = WRITE and 4 = PRECHARGE. Codes 5 to 7 act as NOP.
- R13: While one bank waits for its self-timed precharge, the other banks still accept ACTIVE, READ and WRITE as their own flags allow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_code | input | 3 | Command presented this cycle (see R12) |
| cmd_bank | input | BANK_AW | Target bank of the command |
| cmd_a10 | input | 1 | Auto-precharge on READ/WRITE, all-banks on PRECHARGE |
| act_ok | output | 2**BANK_AW | ACTIVE legal per bank |
| access_ok | output | 2**BANK_AW | READ/WRITE legal per bank |
| pre_ok | output | 2**BANK_AW | Single-bank PRECHARGE legal per bank |
| pre_all_ok | output | 1 | All-banks PRECHARGE legal |
| row_open | output | 2**BANK_AW | A row is open in the bank |

## Verification
One cycle-exact command sequence drives banks through overlapping lives. It mixes plain and self-timed closes, reads and writes, single and all-bank precharges, and activations packed against the spacing window. Each step compares all flags of all four banks. This separates a wrong constant in one counter from a wrong flag combination. Commands that should be rejected are placed where a lax tracker would accept them: a precharge during write recovery, an activation inside the spacing window, and an access to an idle bank. The state seen afterwards shows whether they slipped through. A point where precharge recovery ends one cycle before the row-cycle time tells those two limits apart.

// File: rtl/sdt_pkg.sv
package sdt_pkg;

   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_WR  = 3'd3,
      CMD_PRE = 3'd4
   } sdt_cmd_e;

   function automatic int unsigned imax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned cnt_bits(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/sdt_sat_counter.sv
module sdt_sat_counter #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/sdt_bank_timer.sv
module sdt_bank_timer #(
   parameter int T_RCD     = 3,
   parameter int T_RAS     = 6,
   parameter int T_RP      = 3,
   parameter int T_WR      = 2,
   parameter int T_RC      = 10,
   parameter int BURST_LEN = 4,
   parameter int CW        = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic do_act,
   input  logic do_rd,
   input  logic do_wr,
   input  logic do_pre,
   input  logic ap_req,
   output logic act_ready,
   output logic acc_ready,
   output logic pre_ready,
   output logic is_open,
   output logic ap_busy
);
   // load values: a counter loaded with N-1 reaches zero N cycles later
   localparam logic [CW-1:0] L_RCD = CW'(T_RCD - 1);
   localparam logic [CW-1:0] L_RAS = CW'(T_RAS - 1);
   localparam logic [CW-1:0] L_RC  = CW'(T_RC - 1);
   localparam logic [CW-1:0] L_RP  = CW'(T_RP - 1);
   localparam logic [CW-1:0] L_WRR = CW'(BURST_LEN + T_WR - 2);
   localparam logic [CW-1:0] L_RAP = CW'(BURST_LEN - 1);

   logic open_q, ap_q;
   logic rcd_z, ras_z, rc_z, rp_z, wr_z, ap_z;
   logic ap_set, ap_fire, close;

   assign ap_set  = (do_rd | do_wr) & ap_req;
   assign ap_fire = ap_q & ap_z & ras_z;
   assign close   = do_pre | ap_fire;

   sdt_sat_counter #(.CW(CW)) u_rcd (.clk(clk), .rst_n(rst_n), .load(do_act),
      .load_val(L_RCD), .zero(rcd_z));
   sdt_sat_counter #(.CW(CW)) u_ras (.clk(clk), .rst_n(rst_n), .load(do_act),
      .load_val(L_RAS), .zero(ras_z));
   sdt_sat_counter #(.CW(CW)) u_rc  (.clk(clk), .rst_n(rst_n), .load(do_act),
      .load_val(L_RC), .zero(rc_z));
   sdt_sat_counter #(.CW(CW)) u_rp  (.clk(clk), .rst_n(rst_n), .load(close),
      .load_val(L_RP), .zero(rp_z));
   sdt_sat_counter #(.CW(CW)) u_wr  (.clk(clk), .rst_n(rst_n), .load(do_wr),
      .load_val(L_WRR), .zero(wr_z));
   sdt_sat_counter #(.CW(CW)) u_ap  (.clk(clk), .rst_n(rst_n), .load(ap_set),
      .load_val(do_wr ? L_WRR : L_RAP), .zero(ap_z));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         ap_q   <= 1'b0;
      end else begin
         if (do_act) open_q <= 1'b1;
         if (ap_set) ap_q   <= 1'b1;
         if (close) begin
            open_q <= 1'b0;
            ap_q   <= 1'b0;
         end
      end
   end

   assign act_ready = ~open_q & ~ap_q & rp_z & rc_z;
   assign acc_ready =  open_q & ~ap_q & rcd_z;
   assign pre_ready =  open_q & ~ap_q & ras_z & wr_z;
   assign is_open   =  open_q;
   assign ap_busy   =  ap_q;
endmodule

// File: rtl/sdt_cmd_decode.sv
module sdt_cmd_decode
   import sdt_pkg::*;
#(
   parameter int BANK_AW = 2,
   localparam int NB     = 1 << BANK_AW
) (
   input  logic [2:0]         cmd_code,
   input  logic [BANK_AW-1:0] cmd_bank,
   input  logic               cmd_a10,
   input  logic               space_ok,
   input  logic [NB-1:0]      bank_act_rdy,
   input  logic [NB-1:0]      bank_acc_rdy,
   input  logic [NB-1:0]      bank_pre_rdy,
   input  logic [NB-1:0]      bank_open,
   input  logic [NB-1:0]      bank_busy,
   output logic [NB-1:0]      act_ok,
   output logic [NB-1:0]      acc_ok,
   output logic [NB-1:0]      pre_ok,
   output logic               pre_all_ok,
   output logic [NB-1:0]      do_act,
   output logic [NB-1:0]      do_rd,
   output logic [NB-1:0]      do_wr,
   output logic [NB-1:0]      do_pre,
   output logic               any_act
);
   logic [NB-1:0] sel;

   for (genvar g = 0; g < NB; g++) begin : g_sel
      assign sel[g] = (cmd_bank == BANK_AW'(g));
   end

   always_comb begin
      act_ok     = bank_act_rdy & {NB{space_ok}};
      acc_ok     = bank_acc_rdy;
      pre_ok     = bank_pre_rdy;
      pre_all_ok = &(bank_pre_rdy | (~bank_open & ~bank_busy));
      do_act = '0;
      do_rd  = '0;
      do_wr  = '0;
      do_pre = '0;
      unique case (cmd_code)
         CMD_ACT: do_act = sel & act_ok;
         CMD_RD:  do_rd  = sel & acc_ok;
         CMD_WR:  do_wr  = sel & acc_ok;
         CMD_PRE: do_pre = cmd_a10 ? (bank_open & {NB{pre_all_ok}}) : (sel & pre_ok);
         default: ;
      endcase
      any_act = |do_act;
   end
endmodule

// File: rtl/bank_timing_tracker.sv
module bank_timing_tracker
   import sdt_pkg::*;
#(
   parameter int BANK_AW   = 2,
   parameter int T_RCD     = 3,
   parameter int T_RAS     = 6,
   parameter int T_RP      = 3,
   parameter int T_WR      = 2,
   parameter int T_RRD     = 2,
   parameter int T_RC      = 10,
   parameter int BURST_LEN = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [2:0]                cmd_code,
   input  logic [BANK_AW-1:0]        cmd_bank,
   input  logic                      cmd_a10,
   output logic [(1<<BANK_AW)-1:0]   act_ok,
   output logic [(1<<BANK_AW)-1:0]   access_ok,
   output logic [(1<<BANK_AW)-1:0]   pre_ok,
   output logic                      pre_all_ok,
   output logic [(1<<BANK_AW)-1:0]   row_open
);
   localparam int NB   = 1 << BANK_AW;
   localparam int MAXT = imax(imax(T_RC, T_RAS), imax(BURST_LEN + T_WR, T_RRD));
   localparam int CW   = cnt_bits(MAXT);

   if (BANK_AW < 1 || T_RCD < 1 || T_RAS < 1 || T_RP < 1 || T_WR < 1 ||
       T_RRD < 1 || T_RC < 1 || BURST_LEN < 1) begin : g_bad_param
      $fatal(1, "bank_timing_tracker: every timing parameter must be at least 1");
   end

   logic [NB-1:0] b_act, b_acc, b_pre, b_open, b_busy;
   logic [NB-1:0] do_act, do_rd, do_wr, do_pre;
   logic          any_act, space_ok;

   sdt_sat_counter #(.CW(CW)) u_rrd (
      .clk(clk), .rst_n(rst_n), .load(any_act),
      .load_val(CW'(T_RRD - 1)), .zero(space_ok));

   sdt_cmd_decode #(.BANK_AW(BANK_AW)) u_dec (
      .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_a10(cmd_a10),
      .space_ok(space_ok), .bank_act_rdy(b_act), .bank_acc_rdy(b_acc),
      .bank_pre_rdy(b_pre), .bank_open(b_open), .bank_busy(b_busy),
      .act_ok(act_ok), .acc_ok(access_ok), .pre_ok(pre_ok),
      .pre_all_ok(pre_all_ok), .do_act(do_act), .do_rd(do_rd),
      .do_wr(do_wr), .do_pre(do_pre), .any_act(any_act));

   for (genvar b = 0; b < NB; b++) begin : g_bank
      sdt_bank_timer #(
         .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_WR(T_WR),
         .T_RC(T_RC), .BURST_LEN(BURST_LEN), .CW(CW)
      ) u_bank (
         .clk(clk), .rst_n(rst_n),
         .do_act(do_act[b]), .do_rd(do_rd[b]), .do_wr(do_wr[b]),
         .do_pre(do_pre[b]), .ap_req(cmd_a10),
         .act_ready(b_act[b]), .acc_ready(b_acc[b]), .pre_ready(b_pre[b]),
         .is_open(b_open[b]), .ap_busy(b_busy[b]));
   end

   assign row_open = b_open;
endmodule

// File: rtl/bank_timing_tracker_chk.sv
module bank_timing_tracker_chk
   import sdt_pkg::*;
#(
   parameter int BANK_AW   = 2,
   parameter int T_RCD     = 3,
   parameter int T_RRD     = 2,
   parameter int T_WR      = 2,
   parameter int BURST_LEN = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [2:0]                cmd_code,
   input logic [BANK_AW-1:0]        cmd_bank,
   input logic                      cmd_a10,
   input logic [(1<<BANK_AW)-1:0]   act_ok,
   input logic [(1<<BANK_AW)-1:0]   access_ok,
   input logic [(1<<BANK_AW)-1:0]   pre_ok,
   input logic                      pre_all_ok,
   input logic [(1<<BANK_AW)-1:0]   row_open
);
   localparam int NB = 1 << BANK_AW;

   for (genvar b = 0; b < NB; b++) begin : g_chk
      logic hit;
      assign hit = (cmd_bank == BANK_AW'(b));

      a_r2_opens_row: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_code == CMD_ACT && hit && act_ok[b]) |=> row_open[b]);

      if (T_RCD > 1) begin : g_rcd
         a_r2_no_early_access: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_code == CMD_ACT && hit && act_ok[b]) |=> !access_ok[b]);
      end

      a_r4_single_close: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_code == CMD_PRE && !cmd_a10 && hit && pre_ok[b]) |=> !row_open[b]);

      if (BURST_LEN + T_WR > 2) begin : g_wr
         a_r6_write_recovery: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_code == CMD_WR && hit && access_ok[b]) |=> !pre_ok[b]);
      end

      a_r11_idle_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
         ((cmd_code == CMD_RD || cmd_code == CMD_WR) && hit && !row_open[b] &&
          !act_ok[b] && !pre_ok[b]) |=> !row_open[b] || $past(row_open[b]));

      a_r2_act_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
         act_ok[b] |-> !row_open[b]);
   end

   a_r5_all_close: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_code == CMD_PRE && cmd_a10 && pre_all_ok) |=> (row_open == '0));

   if (T_RRD > 1) begin : g_rrd
      a_r9_act_spacing: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_code == CMD_ACT && act_ok[cmd_bank]) |=> (act_ok == '0));
   end
endmodule

bind bank_timing_tracker bank_timing_tracker_chk #(
   .BANK_AW(BANK_AW), .T_RCD(T_RCD), .T_RRD(T_RRD), .T_WR(T_WR),
   .BURST_LEN(BURST_LEN)
) u_chk (.*);

// File: tb/bank_timing_tracker_tb.sv
`timescale 1ns/1ps
module bank_timing_tracker_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cmd_code = 3'd0;
   logic [1:0] cmd_bank = 2'd0;
   logic       cmd_a10 = 1'b0;
   logic [3:0] act_ok, access_ok, pre_ok, row_open;
   logic       pre_all_ok;
   int         checks = 0;
   int         fails  = 0;

   always #10 clk = ~clk;

   bank_timing_tracker #(
      .BANK_AW(2), .T_RCD(3), .T_RAS(6), .T_RP(3), .T_WR(2),
      .T_RRD(2), .T_RC(10), .BURST_LEN(4)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
      .cmd_a10(cmd_a10), .act_ok(act_ok), .access_ok(access_ok),
      .pre_ok(pre_ok), .pre_all_ok(pre_all_ok), .row_open(row_open));

   // row layout: tag[46:23] cmd[22:20] bank[19:18] a10[17]
   //             open[16:13] act[12:9] access[8:5] pre[4:1] pall[0]
   function automatic logic [46:0] mk(input logic [2:0] c, input logic [1:0] b,
      input logic a, input logic [3:0] o, input logic [3:0] ac,
      input logic [3:0] rd, input logic [3:0] pr, input logic pa,
      input logic [23:0] t);
      return {t, c, b, a, o, ac, rd, pr, pa};
   endfunction

   // expected flags are those seen in the cycle after each command
   localparam logic [46:0] VEC [29] = '{
      mk(3'd1,2'd0,1'b0,4'b0001,4'b0000,4'b0000,4'b0000,1'b0,"R2 "), // act b0
      mk(3'd1,2'd1,1'b0,4'b0001,4'b1110,4'b0000,4'b0000,1'b0,"R9 "), // act in window ignored
      mk(3'd1,2'd1,1'b0,4'b0011,4'b0000,4'b0001,4'b0000,1'b0,"R2 "), // act b1
      mk(3'd3,2'd0,1'b0,4'b0011,4'b1100,4'b0001,4'b0000,1'b0,"R6 "), // write b0
      mk(3'd0,2'd0,1'b0,4'b0011,4'b1100,4'b0011,4'b0000,1'b0,"R2 "),
      mk(3'd4,2'd0,1'b0,4'b0011,4'b1100,4'b0011,4'b0000,1'b0,"R3 "), // early pre ignored
      mk(3'd0,2'd0,1'b0,4'b0011,4'b1100,4'b0011,4'b0000,1'b0,"R6 "),
      mk(3'd0,2'd0,1'b0,4'b0011,4'b1100,4'b0011,4'b0011,1'b1,"R6 "),
      mk(3'd4,2'd0,1'b0,4'b0010,4'b1100,4'b0010,4'b0010,1'b1,"R4 "), // pre b0
      mk(3'd0,2'd0,1'b0,4'b0010,4'b1100,4'b0010,4'b0010,1'b1,"R4 "),
      mk(3'd0,2'd0,1'b0,4'b0010,4'b1101,4'b0010,4'b0010,1'b1,"R4 "),
      mk(3'd2,2'd1,1'b1,4'b0010,4'b1101,4'b0000,4'b0000,1'b0,"R7 "), // read b1 autopre
      mk(3'd1,2'd0,1'b0,4'b0011,4'b0000,4'b0000,4'b0000,1'b0,"R13"), // act b0 meanwhile
      mk(3'd0,2'd0,1'b0,4'b0011,4'b1100,4'b0000,4'b0000,1'b0,"R7 "),
      mk(3'd0,2'd0,1'b0,4'b0011,4'b1100,4'b0001,4'b0000,1'b0,"R7 "),
      mk(3'd0,2'd0,1'b0,4'b0001,4'b1100,4'b0001,4'b0000,1'b0,"R7 "),
      mk(3'd0,2'd0,1'b0,4'b0001,4'b1100,4'b0001,4'b0000,1'b0,"R7 "),
      mk(3'd0,2'd0,1'b0,4'b0001,4'b1110,4'b0001,4'b0001,1'b1,"R7 "),
      mk(3'd3,2'd0,1'b1,4'b0001,4'b1110,4'b0000,4'b0000,1'b0,"R8 "), // write b0 autopre
      mk(3'd1,2'd2,1'b0,4'b0101,4'b0000,4'b0000,4'b0000,1'b0,"R13"), // act b2 meanwhile
      mk(3'd0,2'd0,1'b0,4'b0101,4'b1010,4'b0000,4'b0000,1'b0,"R8 "),
      mk(3'd0,2'd0,1'b0,4'b0101,4'b1010,4'b0100,4'b0000,1'b0,"R8 "),
      mk(3'd0,2'd0,1'b0,4'b0101,4'b1010,4'b0100,4'b0000,1'b0,"R8 "),
      mk(3'd0,2'd0,1'b0,4'b0100,4'b1010,4'b0100,4'b0000,1'b0,"R8 "),
      mk(3'd0,2'd0,1'b0,4'b0100,4'b1010,4'b0100,4'b0100,1'b1,"R3 "),
      mk(3'd4,2'd3,1'b1,4'b0000,4'b1011,4'b0000,4'b0000,1'b1,"R5 "), // pre all
      mk(3'd5,2'd2,1'b0,4'b0000,4'b1011,4'b0000,4'b0000,1'b1,"R12"), // code 5 = nop
      mk(3'd0,2'd0,1'b0,4'b0000,4'b1011,4'b0000,4'b0000,1'b1,"R10"),
      mk(3'd0,2'd0,1'b0,4'b0000,4'b1111,4'b0000,4'b0000,1'b1,"R10")
   };

   function automatic logic [16:0] flags();
      return {row_open, act_ok, access_ok, pre_ok, pre_all_ok};
   endfunction

   task automatic chk(input string tag, input logic [16:0] got, input logic [16:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s open/act/acc/pre/all actual=%b expected=%b", tag, got, exp);
      end
   endtask

   task automatic tick(input logic [2:0] c, input logic [1:0] b, input logic a);
      cmd_code = c;
      cmd_bank = b;
      cmd_a10  = a;
      @(posedge clk);
      @(negedge clk);
      cmd_code = 3'd0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk("R1", flags(), {4'b0000, 4'b1111, 4'b0000, 4'b0000, 1'b1});
      rst_n = 1'b1;
      for (int i = 0; i < 29; i++) begin
         tick(VEC[i][22:20], VEC[i][19:18], VEC[i][17]);
         chk(string'(VEC[i][46:23]), flags(), VEC[i][16:0]);
      end
      // R11: accesses to an idle bank change nothing
      tick(3'd2, 2'd2, 1'b1);
      chk("R11", flags(), {4'b0000, 4'b1111, 4'b0000, 4'b0000, 1'b1});
      tick(3'd3, 2'd1, 1'b0);
      chk("R11", flags(), {4'b0000, 4'b1111, 4'b0000, 4'b0000, 1'b1});
      // R2: activate bank 3
      tick(3'd1, 2'd3, 1'b0);
      chk("R2", flags(), {4'b1000, 4'b0000, 4'b0000, 4'b0000, 1'b0});
      // R1: reset while a row is open
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R1", flags(), {4'b0000, 4'b1111, 4'b0000, 4'b0000, 1'b1});
      rst_n = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule